// File: doc/BRIEF.md
# Settable 24-Hour Timekeeping Core

This block keeps the time of day as six BCD digits (hours, minutes, seconds) and also holds a separate alarm time. It runs from a slow system clock, nominally 1024 Hz. An internal divider turns that clock into a one-second step. Three single-cycle key strobes drive it, and each strobe is assumed to be debounced already. The set strobe opens an edit sequence. The advance strobe moves to the next field. The view strobe swaps between the time view and the alarm view.

In the time view, the edit sequence visits hours, then minutes, then a seconds-clear step, and then returns to normal running. While hours or minutes are selected, that field steps once per second. In the seconds-clear step, the seconds are held at zero. In the alarm view, the same walk visits the alarm hours, minutes and seconds, and each selected alarm field steps once per second. A single-cycle pulse marks the moment the running time first equals the alarm time. Digit scanning, tone generation and key filtering belong to neighbouring blocks.

Top module: `settable_clock_core`

## Requirements
- R1: A synchronous active-high reset sets all twelve time and alarm digits to zero and selects the time view. After reset, no edit flag is set and `alarm_hit` is low.
- R2: Outside the edit states, seconds advance by one every `TICK_DIV` clock cycles, starting from the end of reset. Seconds carry from 59 into minutes, minutes carry from 59 into hours, and the time wraps from 23:59:59 to 00:00:00. Each byte holds tens in bits 7:4 and units in bits 3:0.
- R3: From the running time view, `key_set` enters hours edit. Each `key_adv` then moves the walk to minutes edit, then to seconds-clear, then back to running. The flags `edit_hour`, `edit_min` and `edit_sec` show the current step, and at most one of them is high.
- R4: In hours edit or minutes edit, the selected field grows by one on each one-second step. It wraps 23→00 or 59→00, and this wrap carries into no other field.
- R5: During hours edit, seconds keep counting. Neither edit mode lets a carry from a lower field change the field being edited. During minutes edit, the hours do not change.
- R6: In seconds-clear, the seconds read 00 from the cycle after entry, and the hours and minutes hold.
- R7: In the running time view or the plain alarm view, `key_view` swaps the view, as shown by `alarm_view`. If `key_view` and `key_set` arrive in the same cycle, `key_view` wins. In the edit states, `key_view` is ignored.
- R8: From the alarm view, `key_set` enters alarm-hours set. `key_adv` then steps to alarm-minutes, then to alarm-seconds, then back to the alarm view. The selected alarm field grows by one each second, with the same wraps as in R4. The running time keeps counting throughout. The alarm digits change in no other state.
- R9: `alarm_hit` is high for exactly one cycle, in the cycle after the first cycle in which the time equals the alarm. An equality that already holds when reset is released gives no pulse.
- R10: `key_adv` in either non-edit view has no effect, and `key_set` inside an edit state has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock (nominally 1024 Hz) |
| rst | input | 1 | Synchronous active-high reset |
| key_set | input | 1 | Set strobe, one cycle |
| key_adv | input | 1 | Advance strobe, one cycle |
| key_view | input | 1 | View-toggle strobe, one cycle |
| time_h | output | 8 | Time hours, BCD |
| time_m | output | 8 | Time minutes, BCD |
| time_s | output | 8 | Time seconds, BCD |
| alm_h | output | 8 | Alarm hours, BCD |
| alm_m | output | 8 | Alarm minutes, BCD |
| alm_s | output | 8 | Alarm seconds, BCD |
| edit_hour | output | 1 | Hours field selected for editing (time or alarm) |
| edit_min | output | 1 | Minutes field selected for editing |
| edit_sec | output | 1 | Seconds field selected (clear in time view, set in alarm view) |
| alarm_view | output | 1 | High while the alarm view or an alarm set state is active |
| alarm_hit | output | 1 | One-cycle pulse when time first matches the alarm |

## Verification
A strobe presented before a rising edge shows up in the view and edit flags right after that same edge. A one-second step appears in the digits at the edge where the divider completes its count. Seconds-clear zeroes the seconds one edge after the state is entered. `alarm_hit` trails the first matching cycle by one more edge. The bench drives strobes and samples every output on the falling edge. Its cycle model is updated on each rising edge, so every expected value lines up with the register that produces it. Directed waits poll on the falling edge and then act on the next rising edge. No divider step can fall in between, because the step that was just observed is a full `TICK_DIV` cycles from the next one.

// File: rtl/sclk_pkg.sv
package sclk_pkg;
  localparam int DIGIT_W = 4;
  localparam int FIELD_W = 2 * DIGIT_W;

  typedef enum logic [2:0] {
    M_RUN   = 3'd0,
    M_HOUR  = 3'd1,
    M_MIN   = 3'd2,
    M_SCLR  = 3'd3,
    M_AVIEW = 3'd4,
    M_AHOUR = 3'd5,
    M_AMIN  = 3'd6,
    M_ASEC  = 3'd7
  } mode_e;
endpackage

// File: rtl/sclk_tick.sv
module sclk_tick #(
  parameter int TICK_DIV = 1024
) (
  input  logic clk,
  input  logic rst,
  output logic tick
);
  localparam int CW = (TICK_DIV > 2) ? $clog2(TICK_DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(TICK_DIV - 1);

  logic [CW-1:0] cnt;

  assign tick = (cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst)       cnt <= '0;
    else if (tick) cnt <= '0;
    else           cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/sclk_bcd_field.sv
module sclk_bcd_field #(
  parameter int DW = 4,
  parameter logic [3:0] TOP_TENS = 4'd5,
  parameter logic [3:0] TOP_ONES = 4'd9
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          inc,
  output logic [2*DW-1:0] value,
  output logic          at_top
);
  logic [DW-1:0] tens, ones;

  assign value  = {tens, ones};
  assign at_top = (tens == DW'(TOP_TENS)) && (ones == DW'(TOP_ONES));

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      tens <= '0;
      ones <= '0;
    end else if (inc) begin
      if (at_top) begin
        tens <= '0;
        ones <= '0;
      end else if (ones == DW'(9)) begin
        tens <= tens + 1'b1;
        ones <= '0;
      end else begin
        ones <= ones + 1'b1;
      end
    end
  end
endmodule

// File: rtl/sclk_mode_fsm.sv
module sclk_mode_fsm
  import sclk_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  key_set,
  input  logic  key_adv,
  input  logic  key_view,
  output mode_e mode,
  output logic  edit_hour,
  output logic  edit_min,
  output logic  edit_sec,
  output logic  alarm_view
);
  mode_e nxt;

  always_comb begin
    nxt = mode;
    unique case (mode)
      M_RUN:   if (key_view) nxt = M_AVIEW; else if (key_set) nxt = M_HOUR;
      M_HOUR:  if (key_adv) nxt = M_MIN;
      M_MIN:   if (key_adv) nxt = M_SCLR;
      M_SCLR:  if (key_adv) nxt = M_RUN;
      M_AVIEW: if (key_view) nxt = M_RUN; else if (key_set) nxt = M_AHOUR;
      M_AHOUR: if (key_adv) nxt = M_AMIN;
      M_AMIN:  if (key_adv) nxt = M_ASEC;
      M_ASEC:  if (key_adv) nxt = M_AVIEW;
      default: nxt = M_RUN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode       <= M_RUN;
      edit_hour  <= 1'b0;
      edit_min   <= 1'b0;
      edit_sec   <= 1'b0;
      alarm_view <= 1'b0;
    end else begin
      mode       <= nxt;
      edit_hour  <= (nxt == M_HOUR) || (nxt == M_AHOUR);
      edit_min   <= (nxt == M_MIN)  || (nxt == M_AMIN);
      edit_sec   <= (nxt == M_SCLR) || (nxt == M_ASEC);
      alarm_view <= nxt[2];
    end
  end
endmodule

// File: rtl/settable_clock_core.sv
module settable_clock_core
  import sclk_pkg::*;
#(
  parameter int TICK_DIV = 1024
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               key_set,
  input  logic               key_adv,
  input  logic               key_view,
  output logic [FIELD_W-1:0] time_h,
  output logic [FIELD_W-1:0] time_m,
  output logic [FIELD_W-1:0] time_s,
  output logic [FIELD_W-1:0] alm_h,
  output logic [FIELD_W-1:0] alm_m,
  output logic [FIELD_W-1:0] alm_s,
  output logic               edit_hour,
  output logic               edit_min,
  output logic               edit_sec,
  output logic               alarm_view,
  output logic               alarm_hit
);
  localparam int NF = 3;

  mode_e mode;
  logic  tick;
  logic  s_top, m_top, h_top;
  logic  in_hr, in_mn, in_sc;
  logic  sec_carry, min_inc, min_carry, hr_inc;
  logic  [NF-1:0] alm_sel;
  logic  [FIELD_W-1:0] alm_val [NF];
  logic  match, match_q;

  sclk_tick #(.TICK_DIV(TICK_DIV)) u_tick (.clk(clk), .rst(rst), .tick(tick));

  sclk_mode_fsm u_fsm (
    .clk(clk), .rst(rst), .key_set(key_set), .key_adv(key_adv), .key_view(key_view),
    .mode(mode), .edit_hour(edit_hour), .edit_min(edit_min), .edit_sec(edit_sec),
    .alarm_view(alarm_view)
  );

  assign in_hr     = (mode == M_HOUR);
  assign in_mn     = (mode == M_MIN);
  assign in_sc     = (mode == M_SCLR);
  assign sec_carry = tick && s_top && !in_sc;
  assign min_inc   = in_mn ? tick : (in_sc ? 1'b0 : sec_carry);
  assign min_carry = min_inc && m_top && !in_mn;
  assign hr_inc    = in_hr ? tick : ((in_mn || in_sc) ? 1'b0 : min_carry);

  sclk_bcd_field #(.DW(DIGIT_W), .TOP_TENS(4'd5), .TOP_ONES(4'd9)) u_sec (
    .clk(clk), .rst(rst), .clr(in_sc), .inc(tick), .value(time_s), .at_top(s_top));
  sclk_bcd_field #(.DW(DIGIT_W), .TOP_TENS(4'd5), .TOP_ONES(4'd9)) u_min (
    .clk(clk), .rst(rst), .clr(1'b0), .inc(min_inc), .value(time_m), .at_top(m_top));
  sclk_bcd_field #(.DW(DIGIT_W), .TOP_TENS(4'd2), .TOP_ONES(4'd3)) u_hour (
    .clk(clk), .rst(rst), .clr(1'b0), .inc(hr_inc), .value(time_h), .at_top(h_top));

  // alarm fields: index 0 hours, 1 minutes, 2 seconds
  assign alm_sel = {mode == M_ASEC, mode == M_AMIN, mode == M_AHOUR};

  for (genvar g = 0; g < NF; g++) begin : g_alm
    localparam logic [3:0] TT = (g == 0) ? 4'd2 : 4'd5;
    localparam logic [3:0] TO = (g == 0) ? 4'd3 : 4'd9;
    logic top_unused;
    sclk_bcd_field #(.DW(DIGIT_W), .TOP_TENS(TT), .TOP_ONES(TO)) u_fld (
      .clk(clk), .rst(rst), .clr(1'b0), .inc(tick && alm_sel[g]),
      .value(alm_val[g]), .at_top(top_unused));
  end

  assign alm_h = alm_val[0];
  assign alm_m = alm_val[1];
  assign alm_s = alm_val[2];

  assign match = (time_h == alm_h) && (time_m == alm_m) && (time_s == alm_s);

  always_ff @(posedge clk) begin
    if (rst) begin
      match_q   <= 1'b1;
      alarm_hit <= 1'b0;
    end else begin
      match_q   <= match;
      alarm_hit <= match && !match_q;
    end
  end

  logic unused_ok;
  assign unused_ok = h_top;
endmodule

// File: rtl/sclk_checker.sv
module sclk_checker (
  input logic       clk,
  input logic       rst,
  input logic [7:0] time_h,
  input logic [7:0] time_m,
  input logic [7:0] time_s,
  input logic [7:0] alm_h,
  input logic [7:0] alm_m,
  input logic [7:0] alm_s,
  input logic       edit_hour,
  input logic       edit_min,
  input logic       edit_sec,
  input logic       alarm_view,
  input logic       alarm_hit
);
  a_r9_hit_one_cycle: assert property (@(posedge clk) disable iff (rst)
    alarm_hit |=> !alarm_hit);

  a_r3_one_edit_flag: assert property (@(posedge clk) disable iff (rst)
    $onehot0({edit_hour, edit_min, edit_sec}));

  a_r6_secs_zero: assert property (@(posedge clk) disable iff (rst)
    (edit_sec && !alarm_view) |=> (time_s == 8'h00));

  a_r5_hours_hold_in_min_edit: assert property (@(posedge clk) disable iff (rst)
    (edit_min && !alarm_view) |=> $stable(time_h));

  a_r2_hours_legal: assert property (@(posedge clk) disable iff (rst)
    (time_h <= 8'h23) && (time_h[3:0] <= 4'd9));

  a_r8_alarm_hold: assert property (@(posedge clk) disable iff (rst)
    !alarm_view |=> $stable({alm_h, alm_m, alm_s}));
endmodule

bind settable_clock_core sclk_checker u_chk (.*);

// File: tb/settable_clock_core_test.sv
module settable_clock_core_test;
  localparam int DIV = 16;

  logic clk = 1'b0, rst = 1'b1;
  logic ks = 1'b0, ka = 1'b0, kv = 1'b0;
  logic [7:0] th_o, tm_o, ts_o, ah_o, am_o, as_o;
  logic eh_o, em_o, es_o, av_o, hit_o;
  int total = 0, bad = 0;
  bit live = 0;

  settable_clock_core #(.TICK_DIV(DIV)) uut (
    .clk(clk), .rst(rst), .key_set(ks), .key_adv(ka), .key_view(kv),
    .time_h(th_o), .time_m(tm_o), .time_s(ts_o),
    .alm_h(ah_o), .alm_m(am_o), .alm_s(as_o),
    .edit_hour(eh_o), .edit_min(em_o), .edit_sec(es_o),
    .alarm_view(av_o), .alarm_hit(hit_o));

  always #10 clk = ~clk;

  function automatic int bcd(input logic [7:0] v);
    return int'(v[7:4]) * 10 + int'(v[3:0]);
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic wrap_up;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  // reference model, modes: 0 run 1 hr 2 mn 3 sclr 4 aview 5 ahr 6 amn 7 asec
  int md, th, tm, ts, ah, am, asec, cnt;
  bit eqp, hit, tk, eq;

  always @(posedge clk) begin
    if (rst) begin
      md = 0; th = 0; tm = 0; ts = 0; ah = 0; am = 0; asec = 0;
      cnt = 0; eqp = 1; hit = 0;
    end else begin
      tk  = (cnt == DIV - 1);
      cnt = tk ? 0 : cnt + 1;
      eq  = (th == ah) && (tm == am) && (ts == asec);
      hit = eq && !eqp;
      eqp = eq;
      if (md == 3) ts = 0;
      else if (tk) begin
        case (md)
          1: begin
            th = (th + 1) % 24;
            if (ts == 59) begin ts = 0; tm = (tm + 1) % 60; end else ts++;
          end
          2: begin tm = (tm + 1) % 60; ts = (ts + 1) % 60; end
          default: begin
            ts++;
            if (ts == 60) begin
              ts = 0; tm++;
              if (tm == 60) begin tm = 0; th = (th + 1) % 24; end
            end
          end
        endcase
        if (md == 5) ah = (ah + 1) % 24;
        if (md == 6) am = (am + 1) % 60;
        if (md == 7) asec = (asec + 1) % 60;
      end
      case (md)
        0: md = kv ? 4 : (ks ? 1 : 0);
        4: md = kv ? 0 : (ks ? 5 : 4);
        1, 2, 5, 6: md = ka ? md + 1 : md;
        3: md = ka ? 0 : 3;
        7: md = ka ? 4 : 7;
        default: md = 0;
      endcase
    end
  end

  always @(negedge clk) begin
    if (live && !rst) begin
      chk("R2 hours", bcd(th_o), th);
      chk("R2 minutes", bcd(tm_o), tm);
      chk("R2 seconds", bcd(ts_o), ts);
      chk("R8 alarm hours", bcd(ah_o), ah);
      chk("R8 alarm minutes", bcd(am_o), am);
      chk("R8 alarm seconds", bcd(as_o), asec);
      chk("R3 edit_hour", int'(eh_o), int'(md == 1 || md == 5));
      chk("R3 edit_min", int'(em_o), int'(md == 2 || md == 6));
      chk("R3 edit_sec", int'(es_o), int'(md == 3 || md == 7));
      chk("R7 alarm_view", int'(av_o), int'(md >= 4));
      chk("R9 alarm_hit", int'(hit_o), int'(hit));
    end
  end

  task automatic press(input bit s, input bit a, input bit v);
    ks = s; ka = a; kv = v;
    @(negedge clk);
    ks = 0; ka = 0; kv = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog act=running exp=finished");
    wrap_up();
  end

  initial begin
    int s0, h0;
    bit seen;
    void'($urandom(32'd4242));
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state (one edge after release, before the first step)
    chk("R1 time", int'({th_o, tm_o, ts_o}), 0);
    chk("R1 alarm", int'({ah_o, am_o, as_o}), 0);
    chk("R1 flags", int'({eh_o, em_o, es_o, av_o, hit_o}), 0);
    live = 1;

    // R10 advance ignored in running view
    press(0, 1, 0);
    chk("R10 adv in run view", int'({eh_o, em_o, es_o, av_o}), 0);

    // R3 enter hours edit; R10 set ignored inside edit
    press(1, 0, 0);
    chk("R3 hours edit entered", int'(eh_o), 1);
    h0 = bcd(th_o); s0 = bcd(ts_o);
    press(1, 0, 1);
    chk("R10 set ignored in edit", int'(eh_o), 1);
    chk("R7 view ignored in edit", int'(av_o), 0);
    for (int i = 0; i < 2000 && th_o != 8'h23; i++) @(negedge clk);
    chk("R4 hours reached 23", bcd(th_o), 23);
    chk("R5 seconds kept counting", bcd(ts_o), (s0 + 23 - h0) % 60);

    press(0, 1, 0);
    chk("R3 minutes edit", int'(em_o), 1);
    for (int i = 0; i < 2000 && tm_o != 8'h59; i++) @(negedge clk);
    for (int i = 0; i < 100 && tm_o != 8'h00; i++) @(negedge clk);
    chk("R4 minutes wrap no carry", bcd(th_o), 23);
    for (int i = 0; i < 2000 && tm_o != 8'h59; i++) @(negedge clk);
    chk("R5 hours held in minutes edit", bcd(th_o), 23);

    press(0, 1, 0);
    chk("R3 seconds-clear", int'(es_o), 1);
    repeat (2) @(negedge clk);
    chk("R6 seconds zero", bcd(ts_o), 0);
    repeat (40) @(negedge clk);
    chk("R6 fields hold", int'({th_o, tm_o, ts_o}), int'({8'h23, 8'h59, 8'h00}));
    press(0, 1, 0);
    chk("R3 back to run", int'({eh_o, em_o, es_o}), 0);

    // R2 midnight wrap
    for (int i = 0; i < 2000 && th_o != 8'h00; i++) @(negedge clk);
    chk("R2 midnight", int'({th_o, tm_o, ts_o}), 0);

    // R7 view beats set; R8 alarm walk
    press(1, 0, 1);
    chk("R7 view priority", int'({av_o, eh_o}), 2);
    press(1, 0, 0);
    chk("R8 alarm hours set", int'({av_o, eh_o}), 3);
    press(0, 1, 0);
    for (int i = 0; i < 200 && am_o != 8'h01; i++) @(negedge clk);
    chk("R8 alarm minute set", bcd(am_o), 1);
    press(0, 1, 0);
    press(0, 1, 0);
    chk("R8 back to alarm view", int'({av_o, eh_o, em_o, es_o}), 8);
    press(0, 0, 1);
    chk("R7 back to time view", int'(av_o), 0);

    seen = 0;
    for (int i = 0; i < 3000 && !seen; i++) begin
      @(negedge clk);
      if (hit_o) begin
        seen = 1;
        chk("R9 hit at alarm time", int'({th_o, tm_o, ts_o}), int'({8'h00, 8'h01, 8'h00}));
      end
    end
    chk("R9 hit seen", int'(seen), 1);

    // constrained random strobes
    for (int n = 0; n < 20000; n++) begin
      ks = ($urandom % 40) == 0;
      ka = ($urandom % 30) == 0;
      kv = ($urandom % 50) == 0;
      @(negedge clk);
    end
    ks = 0; ka = 0; kv = 0;
    repeat (4) @(negedge clk);
    wrap_up();
  end
endmodule